// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and a calendar as seven packed-BCD registers: seconds, minutes, hours, day of the week, day of the month, month and a two-digit year. A one-cycle enable pulse, produced elsewhere once per second, advances the seconds. Each field carries into the next one when it wraps. The day-of-month limit follows the current month, and February is lengthened in every year whose two BCD digits form a multiple of four.

Hours are kept in one of two encodings, chosen by a mode bit inside the hour byte. The first is a plain 24-hour count. The second is a 12-hour count with a PM flag. A host loads any single register through a write port, selected by a 3-bit code. All seven registers are always visible on parallel read outputs. Bit 7 of the seconds byte is a run/stop control. While it is set, second pulses are ignored.

Top module: `tcal_clock_calendar`

## Requirements
- R1: Seconds and minutes count 0x00 to 0x59 in BCD. A tick at seconds 0x59 gives 0x00 and advances minutes. Minutes wrapping from 0x59 to 0x00 advances hours.
- R2: With hour bit 6 clear (24-hour mode), hours count 0x00 to 0x23. The step from 0x23 to 0x00 advances both day-of-week and day-of-month.
- R3: With hour bit 6 set (12-hour mode), bit 5 is PM and bits 4:0 hold BCD 01 to 12. The order is 0x52, 0x41 through 0x51, 0x72, 0x61 through 0x71, then back to 0x52. The step from 0x71 to 0x52 advances day-of-week and day-of-month.
- R4: Day-of-week counts 1 to 7 and wraps from 7 to 1.
- R5: Day-of-month wraps to 0x01 after 0x31 in months 0x01, 0x03, 0x05, 0x07, 0x08, 0x10 and 0x12. It wraps after 0x30 in months 0x04, 0x06, 0x09 and 0x11. Each wrap advances the month.
- R6: In month 0x02, day-of-month wraps after 0x29 when the BCD year is divisible by 4 (0x00 included), and after 0x28 otherwise.
- R7: Month counts 0x01 to 0x12 and wraps to 0x01, which advances the year. The year counts 0x00 to 0x99 and wraps to 0x00.
- R8: A write loads the register chosen by the select code: 0 seconds, 1 minutes, 2 hours, 3 day-of-week, 4 day-of-month, 5 month, 6 year. Code 7 changes nothing. The bits that are kept are: all 8 seconds bits, bits 6:0 of minutes and hours, bits 2:0 of day-of-week, bits 5:0 of day-of-month, bits 4:0 of month, and all 8 year bits. Every other bit reads 0.
- R9: A written field takes the written value even when a tick arrives in the same cycle. The other fields still advance as that tick demands.
- R10: While seconds bit 7 is 1, ticks change no field. Clearing the bit with a write lets counting resume.
- R11: After reset the read-out is 00:00:00 in 24-hour mode, day-of-week 1, day-of-month 0x01, month 0x01, year 0x00, with the stop bit clear.
- R12: In a cycle with neither a tick nor a write, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 3 | Register select code for the write |
| wr_data_i | input | 8 | Write data byte |
| sec_o | output | 8 | Stop bit and BCD seconds |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Hour byte with mode and PM bits |
| wday_o | output | 8 | Day of week, 1 to 7 |
| mday_o | output | 8 | BCD day of month |
| mon_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |

## Verification
The bench loads the clock to just before each boundary and checks the wrap. The boundaries are 23:59:59 on 31 December of year 99, every month length, February of leap and ordinary years (including year 00 and year 12, whose tens digit is odd), and each turn of the 12-hour dial. A design that reads the leap rule off the low nibble alone would give February 1 March instead of 29 February in year 12. A design that swaps the PM toggle points would go from 11 AM to 12 AM, or would fail to advance the day after 11 PM. The bench also writes a field in the same cycle as a tick that would carry into it. A design that lets the tick win, or that drops the tick for every field, shows a wrong minute or second. Masked writes, the ignored select code and the stop bit are checked through the read-out. A design that keeps a reserved bit or that counts while stopped shows the difference there.

// File: rtl/tcal_pkg.sv
package tcal_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned SEL_W      = 3;
  localparam int unsigned NUM_FIELDS = 7;

  localparam int unsigned IDX_SEC  = 0;
  localparam int unsigned IDX_MIN  = 1;
  localparam int unsigned IDX_HOUR = 2;
  localparam int unsigned IDX_WDAY = 3;
  localparam int unsigned IDX_DATE = 4;
  localparam int unsigned IDX_MON  = 5;
  localparam int unsigned IDX_YEAR = 6;

  localparam int unsigned SEC_W  = 7;
  localparam int unsigned HOUR_W = 7;
  localparam int unsigned WDAY_W = 4;
  localparam int unsigned DATE_W = 6;
  localparam int unsigned MON_W  = 5;

  typedef logic [BYTE_W-1:0] bcd_byte_t;
endpackage

// File: rtl/tcal_ring.sv
module tcal_ring #(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic [W-1:0] q_o,
  output logic         wrap_o
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic [W-1:0] succ;
  logic         en;

  // BCD successor: units digit 9 steps by 7 to land on the next tens value
  always_comb begin
    succ = (q_r[3:0] == 4'd9) ? q_r + W'(7) : q_r + W'(1);
    en   = ld_i | adv_i;
    q_nxt = q_r;
    if (ld_i)
      q_nxt = ld_val_i;
    else if (adv_i)
      q_nxt = (q_r == hi_i) ? lo_i : succ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q_r <= RST_VAL;
    else if (en)
      q_r <= q_nxt;
  end

  assign q_o    = q_r;
  assign wrap_o = adv_i && (q_r == hi_i);
endmodule

// File: rtl/tcal_hour.sv
module tcal_hour
  import tcal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              ld_i,
  input  logic [HOUR_W-1:0] ld_val_i,
  output logic [HOUR_W-1:0] q_o,
  output logic              wrap_o
);
  logic [HOUR_W-1:0] q_r;
  logic [HOUR_W-1:0] q_nxt;
  logic [HOUR_W-1:0] step_val;
  logic              day_end;
  logic [4:0]        h12_succ;
  logic [5:0]        h24_succ;
  logic              en;

  // bit 6: 12-hour mode, bit 5: PM flag in that mode
  always_comb begin
    h12_succ = (q_r[3:0] == 4'd9) ? q_r[4:0] + 5'd7 : q_r[4:0] + 5'd1;
    h24_succ = (q_r[3:0] == 4'd9) ? q_r[5:0] + 6'd7 : q_r[5:0] + 6'd1;
    day_end  = 1'b0;
    if (q_r[6]) begin
      if (q_r[4:0] == 5'h12) begin
        step_val = {1'b1, q_r[5], 5'h01};
      end else if (q_r[4:0] == 5'h11) begin
        step_val = {1'b1, ~q_r[5], 5'h12};
        day_end  = q_r[5];
      end else begin
        step_val = {1'b1, q_r[5], h12_succ};
      end
    end else begin
      if (q_r[5:0] == 6'h23) begin
        step_val = '0;
        day_end  = 1'b1;
      end else begin
        step_val = {1'b0, h24_succ};
      end
    end
    en    = ld_i | adv_i;
    q_nxt = ld_i ? ld_val_i : (adv_i ? step_val : q_r);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q_r <= '0;
    else if (en)
      q_r <= q_nxt;
  end

  assign q_o    = q_r;
  assign wrap_o = adv_i && day_end;
endmodule

// File: rtl/tcal_month_len.sv
module tcal_month_len
  import tcal_pkg::*;
(
  input  logic [MON_W-1:0]  mon_i,
  input  bcd_byte_t         year_i,
  output logic [DATE_W-1:0] last_o
);
  logic [1:0] rem4;
  logic       leap;

  // (10*t + u) mod 4 equals (2*t + u) mod 4
  always_comb begin
    rem4 = year_i[1:0] + {year_i[4], 1'b0};
    leap = (rem4 == 2'b00);
    case (mon_i)
      5'h02:                      last_o = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_o = 6'h30;
      default:                    last_o = 6'h31;
    endcase
  end
endmodule

// File: rtl/tcal_clock_calendar.sv
module tcal_clock_calendar
  import tcal_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [7:0]       wr_data_i,
  output logic [7:0]       sec_o,
  output logic [7:0]       min_o,
  output logic [7:0]       hour_o,
  output logic [7:0]       wday_o,
  output logic [7:0]       mday_o,
  output logic [7:0]       mon_o,
  output logic [7:0]       year_o
);
  logic [NUM_FIELDS-1:0] ld_vec;
  logic                  halt_r;
  logic                  halt_nxt;
  logic                  adv_sec;
  logic                  sec_wrap, min_wrap, day_wrap, wday_wrap, date_wrap, mon_wrap, year_wrap;
  logic [SEC_W-1:0]      sec_q, min_q;
  logic [HOUR_W-1:0]     hour_q;
  logic [WDAY_W-1:0]     wday_q;
  logic [DATE_W-1:0]     date_q, last_date;
  logic [MON_W-1:0]      mon_q;
  bcd_byte_t             year_q;

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_ld
    assign ld_vec[gi] = wr_en_i && (wr_sel_i == SEL_W'(gi));
  end

  always_comb begin
    halt_nxt = wr_data_i[7];
    adv_sec  = tick_i && !halt_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      halt_r <= 1'b0;
    else if (ld_vec[IDX_SEC])
      halt_r <= halt_nxt;
  end

  tcal_ring #(.W(SEC_W), .RST_VAL('0)) i_sec (
    .clk(clk), .rst_n(rst_n), .adv_i(adv_sec), .ld_i(ld_vec[IDX_SEC]),
    .ld_val_i(wr_data_i[SEC_W-1:0]), .lo_i(7'h00), .hi_i(7'h59),
    .q_o(sec_q), .wrap_o(sec_wrap));

  tcal_ring #(.W(SEC_W), .RST_VAL('0)) i_min (
    .clk(clk), .rst_n(rst_n), .adv_i(sec_wrap), .ld_i(ld_vec[IDX_MIN]),
    .ld_val_i(wr_data_i[SEC_W-1:0]), .lo_i(7'h00), .hi_i(7'h59),
    .q_o(min_q), .wrap_o(min_wrap));

  tcal_hour i_hour (
    .clk(clk), .rst_n(rst_n), .adv_i(min_wrap), .ld_i(ld_vec[IDX_HOUR]),
    .ld_val_i(wr_data_i[HOUR_W-1:0]), .q_o(hour_q), .wrap_o(day_wrap));

  tcal_ring #(.W(WDAY_W), .RST_VAL(4'h1)) i_wday (
    .clk(clk), .rst_n(rst_n), .adv_i(day_wrap), .ld_i(ld_vec[IDX_WDAY]),
    .ld_val_i({1'b0, wr_data_i[2:0]}), .lo_i(4'h1), .hi_i(4'h7),
    .q_o(wday_q), .wrap_o(wday_wrap));

  tcal_month_len i_mlen (.mon_i(mon_q), .year_i(year_q), .last_o(last_date));

  tcal_ring #(.W(DATE_W), .RST_VAL(6'h01)) i_date (
    .clk(clk), .rst_n(rst_n), .adv_i(day_wrap), .ld_i(ld_vec[IDX_DATE]),
    .ld_val_i(wr_data_i[DATE_W-1:0]), .lo_i(6'h01), .hi_i(last_date),
    .q_o(date_q), .wrap_o(date_wrap));

  tcal_ring #(.W(MON_W), .RST_VAL(5'h01)) i_mon (
    .clk(clk), .rst_n(rst_n), .adv_i(date_wrap), .ld_i(ld_vec[IDX_MON]),
    .ld_val_i(wr_data_i[MON_W-1:0]), .lo_i(5'h01), .hi_i(5'h12),
    .q_o(mon_q), .wrap_o(mon_wrap));

  tcal_ring #(.W(BYTE_W), .RST_VAL('0)) i_year (
    .clk(clk), .rst_n(rst_n), .adv_i(mon_wrap), .ld_i(ld_vec[IDX_YEAR]),
    .ld_val_i(wr_data_i), .lo_i(8'h00), .hi_i(8'h99),
    .q_o(year_q), .wrap_o(year_wrap));

  assign sec_o  = {halt_r, sec_q};
  assign min_o  = {1'b0, min_q};
  assign hour_o = {1'b0, hour_q};
  assign wday_o = {4'b0, wday_q};
  assign mday_o = {2'b0, date_q};
  assign mon_o  = {3'b0, mon_q};
  assign year_o = year_q;
endmodule

// File: rtl/tcal_checker.sv
module tcal_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       wr_en_i,
  input logic [2:0] wr_sel_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] wday_o,
  input logic [7:0] mday_o,
  input logic [7:0] mon_o,
  input logic [7:0] year_o,
  input logic       wday_wrap,
  input logic       year_wrap
);
  p_sec_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !wr_en_i && sec_o == 8'h59) |=> sec_o == 8'h00);

  p_min_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !wr_en_i && sec_o == 8'h59 && min_o == 8'h59) |=> min_o == 8'h00);

  p_pm_to_am_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !wr_en_i && sec_o == 8'h59 && min_o == 8'h59 && hour_o == 8'h71)
      |=> hour_o == 8'h52);

  p_wday_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wday_wrap && !wr_en_i) |=> wday_o == 8'h01);

  p_year_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (year_wrap && !wr_en_i) |=> (year_o == 8'h00 && mon_o == 8'h01));

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 3'd1) |=> min_o == {1'b0, $past(wr_data_i[6:0])});

  p_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o[7] && !wr_en_i) |=> ($stable(sec_o) && $stable(min_o)));

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !wr_en_i) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
      $stable(wday_o) && $stable(mday_o) && $stable(mon_o) && $stable(year_o)));
endmodule

bind tcal_clock_calendar tcal_checker i_tcal_checker (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
  .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
  .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o),
  .wday_wrap(wday_wrap), .year_wrap(year_wrap));

// File: tb/test_tcal_clock_calendar.sv
module test_tcal_clock_calendar;
  logic       clk;
  logic       rst_n;
  logic       tick_i;
  logic       wr_en_i;
  logic [2:0] wr_sel_i;
  logic [7:0] wr_data_i;
  logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o;

  tcal_clock_calendar i_tcal_clock_calendar (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
    .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o));

  typedef struct {
    logic [55:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int    n_vec  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  logic [7:0] e_sec, e_min, e_hour, e_wday, e_date, e_mon, e_year;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int days_in(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  // reference model of one clock edge, from the requirements
  task automatic model_edge(input logic tk, input logic we, input logic [2:0] sel, input logic [7:0] d);
    logic [7:0] n_sec, n_min, n_hour, n_wday, n_date, n_mon, n_year;
    int s, m, h24, h12, wd, dt, mo, yr;
    bit c;
    n_sec = e_sec; n_min = e_min; n_hour = e_hour; n_wday = e_wday;
    n_date = e_date; n_mon = e_mon; n_year = e_year;
    if (tk && !e_sec[7]) begin
      s = b2i({1'b0, e_sec[6:0]}) + 1; c = (s == 60); if (c) s = 0;
      n_sec = i2b(s);
      if (c) begin
        m = b2i(e_min) + 1; c = (m == 60); if (m == 60) m = 0;
        n_min = i2b(m);
      end
      if (c) begin
        if (e_hour[6]) begin
          h12 = b2i({3'b0, e_hour[4:0]});
          h24 = (h12 % 12) + (e_hour[5] ? 12 : 0);
        end else h24 = b2i({2'b0, e_hour[5:0]});
        h24 = h24 + 1; c = (h24 == 24); if (c) h24 = 0;
        if (e_hour[6]) begin
          h12 = (h24 % 12 == 0) ? 12 : h24 % 12;
          n_hour = {1'b0, 1'b1, (h24 >= 12), i2b(h12)[4:0]};
        end else n_hour = i2b(h24);
      end
      if (c) begin
        wd = int'(e_wday) + 1; if (wd == 8) wd = 1; n_wday = 8'(wd);
        mo = b2i(e_mon); yr = b2i(e_year);
        dt = b2i(e_date) + 1; c = (dt > days_in(mo, yr)); if (c) dt = 1;
        n_date = i2b(dt);
        if (c) begin
          mo = mo + 1; c = (mo == 13); if (c) mo = 1; n_mon = i2b(mo);
          if (c) begin yr = (yr + 1) % 100; n_year = i2b(yr); end
        end
      end
    end
    if (we) begin
      case (sel)
        3'd0: n_sec  = d;
        3'd1: n_min  = {1'b0, d[6:0]};
        3'd2: n_hour = {1'b0, d[6:0]};
        3'd3: n_wday = {5'b0, d[2:0]};
        3'd4: n_date = {2'b0, d[5:0]};
        3'd5: n_mon  = {3'b0, d[4:0]};
        3'd6: n_year = d;
        default: ;
      endcase
    end
    e_sec = n_sec; e_min = n_min; e_hour = n_hour; e_wday = n_wday;
    e_date = n_date; e_mon = n_mon; e_year = n_year;
  endtask

  // driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic step(input logic tk, input logic we, input logic [2:0] sel,
                      input logic [7:0] d, input string tag);
    item_t it;
    @(negedge clk); #1;
    tick_i = tk; wr_en_i = we; wr_sel_i = sel; wr_data_i = d;
    model_edge(tk, we, sel, d);
    it.exp = {e_sec, e_min, e_hour, e_wday, e_date, e_mon, e_year};
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d, input string tag);
    step(1'b0, 1'b1, sel, d, tag);
  endtask

  task automatic tk(input string tag);
    step(1'b1, 1'b0, 3'd0, 8'h00, tag);
  endtask

  task automatic hour_edge(input logic [7:0] h, input string tag);
    wr(3'd2, h, tag); wr(3'd1, 8'h59, tag); wr(3'd0, 8'h59, tag); tk(tag);
  endtask

  task automatic day_edge(input logic [7:0] dt, input logic [7:0] mo, input logic [7:0] yr, input string tag);
    wr(3'd4, dt, tag); wr(3'd5, mo, tag); wr(3'd6, yr, tag); hour_edge(8'h23, tag);
  endtask

  // monitor: compares outputs well after each active edge
  always @(posedge clk) begin
    item_t it;
    logic [55:0] got;
    #5;
    if (sb_q.size() > 0) begin
      it  = sb_q.pop_front();
      got = {sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o};
      n_vec++;
      if (got !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; wr_en_i = 1'b0; wr_sel_i = 3'd0; wr_data_i = 8'h00;
    e_sec = 8'h00; e_min = 8'h00; e_hour = 8'h00; e_wday = 8'h01;
    e_date = 8'h01; e_mon = 8'h01; e_year = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 3'd0, 8'h00, "R11 reset state");

    // R8 loads, R1/R2/R4/R7 full rollover
    wr(3'd0, 8'h58, "R8 load seconds"); wr(3'd1, 8'h59, "R8 load minutes");
    wr(3'd2, 8'h23, "R8 load hours");   wr(3'd3, 8'h07, "R8 load weekday");
    wr(3'd4, 8'h31, "R8 load date");    wr(3'd5, 8'h12, "R8 load month");
    wr(3'd6, 8'h99, "R8 load year");
    tk("R1 seconds step");
    tk("R7 R2 R4 full rollover to year 00");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 3'd0, 8'h00, "R12 idle hold");
    for (int i = 0; i < 3; i++) tk("R1 plain seconds count");

    // R3 12-hour dial
    hour_edge(8'h51, "R3 11AM to 12PM");
    hour_edge(8'h71, "R3 11PM to 12AM day advance");
    hour_edge(8'h52, "R3 12AM to 01AM");
    hour_edge(8'h72, "R3 12PM to 01PM");
    hour_edge(8'h69, "R3 09PM to 10PM");
    // R2 24-hour BCD steps
    hour_edge(8'h09, "R2 09 to 10");
    hour_edge(8'h19, "R2 19 to 20");

    // R5 month lengths, R4 weekday mid-range
    wr(3'd3, 8'h03, "R4 load weekday");
    day_edge(8'h30, 8'h04, 8'h21, "R5 30 April wraps");
    day_edge(8'h30, 8'h01, 8'h21, "R5 30 January continues");
    day_edge(8'h31, 8'h08, 8'h21, "R5 31 August wraps");
    day_edge(8'h30, 8'h11, 8'h21, "R5 30 November wraps");
    // R6 February
    day_edge(8'h28, 8'h02, 8'h24, "R6 leap year 24 gets 29th");
    day_edge(8'h28, 8'h02, 8'h23, "R6 year 23 ends at 28th");
    day_edge(8'h29, 8'h02, 8'h00, "R6 year 00 ends at 29th");
    day_edge(8'h28, 8'h02, 8'h12, "R6 leap year 12 gets 29th");
    day_edge(8'h28, 8'h02, 8'h10, "R6 year 10 ends at 28th");
    day_edge(8'h31, 8'h12, 8'h41, "R7 year 41 to 42");

    // R8 masking and ignored select
    wr(3'd7, 8'hAA, "R8 select 7 ignored");
    wr(3'd3, 8'hFF, "R8 weekday mask");
    wr(3'd1, 8'hB5, "R8 minutes mask");
    wr(3'd4, 8'hF1, "R8 date mask");
    wr(3'd5, 8'hE9, "R8 month mask");
    wr(3'd2, 8'hA7, "R8 hour mask");

    // R9 write over tick
    wr(3'd0, 8'h59, "R9 setup");
    step(1'b1, 1'b1, 3'd1, 8'h30, "R9 minute write beats carry");
    step(1'b1, 1'b1, 3'd0, 8'h20, "R9 second write beats tick");

    // R10 stop bit
    wr(3'd0, 8'h85, "R10 set stop bit");
    for (int i = 0; i < 3; i++) tk("R10 ticks ignored while stopped");
    wr(3'd0, 8'h05, "R10 clear stop bit");
    tk("R10 counting resumes");

    @(negedge clk); tick_i = 1'b0; wr_en_i = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule